// File: doc/BRIEF.md
# Indexed Block Register Slave for a Two-Wire Serial Bus

This block lets a host on a two-wire open-drain serial bus program a small bank of eight byte-wide control registers that steer a clock generator. Each transfer names a starting register index and then moves a counted run of bytes, so several neighbouring registers can be updated or inspected in one bus transaction. The register contents are presented in parallel to the surrounding clock-control logic, and two of the registers are read-only views: one reflects the live frequency-select inputs, the other carries fixed identification nibbles.

A write goes: START, device byte 0xD2, index, count, then the counted data bytes, STOP. A read first writes the index after 0xD2, then issues a repeated START with 0xD3; the slave answers with a count byte followed by register contents from the index upward until the host refuses a byte. The bus pins are oversampled by the local clock; the slave only ever pulls SDA low, and releases it otherwise.

Top module: `smb_idx_regs`

## Requirements
- R1: The slave acknowledges the device byte 0xD2 (write) and 0xD3 (read); any other device byte is not acknowledged and every following byte up to the next START is neither acknowledged nor acted on.
- R2: In a write, the index byte, the count byte and each counted data byte are acknowledged, and data byte k is stored at register N+k.
- R3: In a read, the first byte returned is the count value of the most recent write transaction (reset value 8), followed by register N, N+1, and so on.
- R4: Only the low three bits of the index are used, and the register pointer wraps from 7 to 0 on both writes and reads.
- R5: A data byte beyond the written count is not acknowledged and does not change any register.
- R6: When the host does not acknowledge a read byte, the slave releases SDA and stays silent until the next START.
- R7: Register 0 reads as {000000, fsel_i[1], fsel_i[0]} and ignores writes.
- R8: Register 7 reads as {REV_ID, VEN_ID} (default 0x21) and ignores writes.
- R9: After reset, registers 1 to 6 hold 0x0F, 0x00, 0xFF, 0xC7, 0xDF, 0x03.
- R10: Reserved bits read as 0 and ignore writes: register 1 bits 6:4, register 2 bits 2:0, register 6 bits 6 and 3.
- R11: The slave changes its SDA pull-down only while SCL is low.
- R12: cfg_o carries register i on bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| sda_drive_o | output | 1 | 1 pulls SDA low, 0 releases it |
| fsel_i | input | 2 | Frequency-select pin levels, reflected in register 0 |
| cfg_o | output | 64 | All register contents, register i on bits [8i+7:8i] |

## Verification
The hardest situation to reach is the slave's silence after a host refusal in the middle of a read: the bench must complete a repeated-START read, refuse a byte, and then keep clocking a full further byte with SDA released so that any stray pull-down shows up as a zero bit. The same approach covers a rejected device byte, where index-, count- and data-shaped bytes follow and both the missing acknowledges and the unchanged register outputs are checked. Pointer wrap is reached by writing and reading runs that start at index 6.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_IDX,
        ST_IDX_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } link_st_e;

    // Bits a host write may change, per register slot
    function automatic logic [7:0] wmask(input int idx);
        case (idx)
            1:       wmask = 8'h8F;
            2:       wmask = 8'hF8;
            3, 4, 5: wmask = 8'hFF;
            6:       wmask = 8'hB7;
            default: wmask = 8'h00;
        endcase
    endfunction

    // Power-on contents per register slot
    function automatic logic [7:0] rstval(input int idx);
        case (idx)
            1:       rstval = 8'h0F;
            3:       rstval = 8'hFF;
            4:       rstval = 8'hC7;
            5:       rstval = 8'hDF;
            6:       rstval = 8'h03;
            default: rstval = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.scl   = {s_q.scl[STAGES-2:0], scl_i};
        s_d.sda   = {s_q.sda[STAGES-2:0], sda_i};
        s_d.scl_p = s_q.scl[STAGES-1];
        s_d.sda_p = s_q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_s    = s_q.scl[STAGES-1];
    assign sda_s    = s_q.sda[STAGES-1];
    assign scl_rise = scl_s & ~s_q.scl_p;
    assign scl_fall = ~scl_s & s_q.scl_p;
    // data edges while the clock line stays high mark bus framing
    assign start_p  = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign stop_p   = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_pkg::*;
#(
    parameter int         NREG   = 8,
    parameter logic [3:0] REV_ID = 4'h2,
    parameter logic [3:0] VEN_ID = 4'h1,
    localparam int        AW     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_data,
    input  logic [1:0]        fsel_i,
    output logic [NREG*8-1:0] cfg_o
);

    logic [7:0] view [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g == 0) begin : g_fsel
            assign view[g] = {6'b0, fsel_i};
        end else if (g == NREG - 1) begin : g_ident
            assign view[g] = {REV_ID, VEN_ID};
        end else begin : g_rw
            logic [7:0] r_d, r_q;

            always_comb begin
                r_d = r_q;
                if (wr_en && wr_addr == AW'(g)) begin
                    r_d = wr_data & wmask(g);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_q <= rstval(g) & wmask(g);
                end else begin
                    r_q <= r_d;
                end
            end

            assign view[g] = r_q;
        end
        assign cfg_o[g*8 +: 8] = view[g];
    end

    assign rd_data = view[rd_addr];

endmodule

// File: rtl/smb_link.sv
module smb_link
    import smb_pkg::*;
#(
    parameter int         NREG     = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    localparam int        AW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_p,
    input  logic          stop_p,
    input  logic          sda_s,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_drive_o
);

    typedef struct packed {
        link_st_e      st;
        logic [7:0]    sh;
        logic [3:0]    bits;
        logic [AW-1:0] ptr;
        logic [7:0]    remain;
        logic [7:0]    count;
        logic          rnw;
        logic          mack;
        logic          drive;
    } link_t;

    link_t l_d, l_q;
    logic  rx_st;
    logic  byte_end;

    assign rx_st    = (l_q.st == ST_ADDR) || (l_q.st == ST_IDX) ||
                      (l_q.st == ST_CNT)  || (l_q.st == ST_WR);
    assign byte_end = rx_st && scl_fall && (l_q.bits == 4'd8);

    always_comb begin
        l_d   = l_q;
        wr_en = 1'b0;
        if (stop_p) begin
            l_d.st    = ST_IDLE;
            l_d.drive = 1'b0;
        end else if (start_p) begin
            l_d.st    = ST_ADDR;
            l_d.bits  = 4'd0;
            l_d.drive = 1'b0;
        end else if (rx_st && scl_rise && l_q.bits < 4'd8) begin
            l_d.sh   = {l_q.sh[6:0], sda_s};
            l_d.bits = l_q.bits + 4'd1;
        end else if (byte_end) begin
            l_d.bits = 4'd0;
            case (l_q.st)
                ST_ADDR: begin
                    if (l_q.sh[7:1] == DEV_ADDR) begin
                        l_d.rnw   = l_q.sh[0];
                        l_d.drive = 1'b1;
                        l_d.st    = ST_ADDR_ACK;
                    end else begin
                        l_d.st = ST_SKIP;
                    end
                end
                ST_IDX: begin
                    l_d.ptr   = l_q.sh[AW-1:0];
                    l_d.drive = 1'b1;
                    l_d.st    = ST_IDX_ACK;
                end
                ST_CNT: begin
                    l_d.count  = l_q.sh;
                    l_d.remain = l_q.sh;
                    l_d.drive  = 1'b1;
                    l_d.st     = ST_CNT_ACK;
                end
                default: begin
                    if (l_q.remain != 8'd0) begin
                        wr_en      = 1'b1;
                        l_d.ptr    = l_q.ptr + AW'(1);
                        l_d.remain = l_q.remain - 8'd1;
                        l_d.drive  = 1'b1;
                        l_d.st     = ST_WR_ACK;
                    end else begin
                        l_d.st = ST_SKIP;
                    end
                end
            endcase
        end else begin
            case (l_q.st)
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (l_q.rnw) begin
                            l_d.sh    = l_q.count;
                            l_d.drive = ~l_q.count[7];
                            l_d.st    = ST_TX;
                        end else begin
                            l_d.drive = 1'b0;
                            l_d.st    = ST_IDX;
                        end
                    end
                end
                ST_IDX_ACK: begin
                    if (scl_fall) begin
                        l_d.drive = 1'b0;
                        l_d.st    = ST_CNT;
                    end
                end
                ST_CNT_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        l_d.drive = 1'b0;
                        l_d.st    = ST_WR;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (l_q.bits == 4'd7) begin
                            l_d.bits  = 4'd0;
                            l_d.drive = 1'b0;
                            l_d.st    = ST_TX_ACK;
                        end else begin
                            l_d.bits  = l_q.bits + 4'd1;
                            l_d.sh    = {l_q.sh[6:0], 1'b0};
                            l_d.drive = ~l_q.sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        l_d.mack = ~sda_s;
                    end
                    if (scl_fall) begin
                        if (l_q.mack) begin
                            l_d.sh    = rd_data;
                            l_d.drive = ~rd_data[7];
                            l_d.ptr   = l_q.ptr + AW'(1);
                            l_d.st    = ST_TX;
                        end else begin
                            l_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q       <= '0;
            l_q.st    <= ST_IDLE;
            l_q.count <= 8'(NREG);
        end else begin
            l_q <= l_d;
        end
    end

    assign rd_addr     = l_q.ptr;
    assign wr_addr     = l_q.ptr;
    assign wr_data     = l_q.sh;
    assign sda_drive_o = l_q.drive;

endmodule

// File: rtl/smb_idx_regs.sv
module smb_idx_regs
    import smb_pkg::*;
#(
    parameter int         NREG        = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [3:0] REV_ID      = 4'h2,
    parameter logic [3:0] VEN_ID      = 4'h1,
    parameter int         SYNC_STAGES = 2,
    localparam int        AW          = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_o,
    input  logic [1:0]        fsel_i,
    output logic [NREG*8-1:0] cfg_o
);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [7:0]    rd_data, wr_data;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          wr_en;

    smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    smb_link #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_p     (start_p),
        .stop_p      (stop_p),
        .sda_s       (sda_s),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sda_drive_o (sda_drive_o)
    );

    smb_regbank #(.NREG(NREG), .REV_ID(REV_ID), .VEN_ID(VEN_ID)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .fsel_i  (fsel_i),
        .cfg_o   (cfg_o)
    );

endmodule

// File: rtl/smb_idx_regs_chk.sv
module smb_idx_regs_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scl_s,
    input logic         sda_drive,
    input logic [1:0]   fsel,
    input logic [W-1:0] cfg
);

    // R11
    drive_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive != $past(sda_drive)) |-> !$past(scl_s));

    // R2
    store_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[55:8] != $past(cfg[55:8])) |-> !$past(scl_s));

    // R9
    reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cfg[55:8] == 48'h03DF_C7FF_000F));

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[14:12] == 3'b000) && (cfg[18:16] == 3'b000) && !cfg[54] && !cfg[51]);

    // R7
    fsel_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[7:0] == {6'b0, fsel});

    // R8
    ident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg[W-1:W-8]));

endmodule

bind smb_idx_regs smb_idx_regs_chk #(.W(NREG*8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_drive (sda_drive_o),
    .fsel      (fsel_i),
    .cfg       (cfg_o)
);

// File: tb/tb_smb_idx_regs.sv
module tb_smb_idx_regs;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [1:0]  fsel = 2'b10;
    logic        drive;
    logic [63:0] cfg;
    logic        sda_line;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    item_t       exp_q[$];
    logic [7:0]  act_q[$];
    logic [7:0]  mreg[8];
    logic [7:0]  mmask[8];
    logic [7:0]  mcount;
    logic        scl_seen = 1'b1;
    logic        drive_prev = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~drive;

    smb_idx_regs dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_drive_o (drive),
        .fsel_i      (fsel),
        .cfg_o       (cfg)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (act_q.size() > 0) begin
            logic [7:0] a;
            a = act_q.pop_front();
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected item actual=%h expected=none", a);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                if (a !== e.v) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, a, e.v);
                end
            end
        end
    end

    // R11: pull-down may only move while SCL is low
    always @(posedge clk) scl_seen <= m_scl;
    always @(negedge clk) begin
        if (rst_n && drive !== drive_prev) begin
            checks++;
            if (scl_seen) begin
                fails++;
                $display("FAIL R11 actual=scl_high expected=scl_low");
            end
        end
        drive_prev <= drive;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        m_sda = b;
        wclk(4);
        m_scl = 1'b1;
        wclk(4);
        r = sda_line;
        wclk(4);
        m_scl = 1'b0;
        wclk(4);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        wclk(4);
        m_scl = 1'b1;
        wclk(8);
        m_sda = 1'b0;
        wclk(8);
        m_scl = 1'b0;
        wclk(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        wclk(4);
        m_scl = 1'b1;
        wclk(8);
        m_sda = 1'b1;
        wclk(8);
    endtask

    task automatic expect_item(input logic [7:0] v, input string tag);
        item_t it;
        it.v = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // sends a byte and pushes 1 for acknowledge, 0 for refusal
    task automatic send_byte(input logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) xbit(b[i], r);
        xbit(1'b1, r);
        act_q.push_back({7'b0, ~r});
    endtask

    task automatic recv_byte(input logic ack);
        logic [7:0] v;
        logic r;
        for (int i = 7; i >= 0; i--) begin
            xbit(1'b1, r);
            v[i] = r;
        end
        xbit(~ack, r);
        act_q.push_back(v);
    endtask

    function automatic logic [7:0] view(input int i);
        if (i == 0) return {6'b0, fsel};
        if (i == 7) return 8'h21;
        return mreg[i];
    endfunction

    task automatic write_blk(input logic [7:0] idx, input logic [7:0] cnt, input int n,
                             input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input logic [7:0] d3);
        logic [7:0] d [4];
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        bus_start();
        expect_item(8'd1, "R1 write device ack");
        send_byte(8'hD2);
        expect_item(8'd1, "R2 index ack");
        send_byte(idx);
        expect_item(8'd1, "R2 count ack");
        send_byte(cnt);
        mcount = cnt;
        for (int k = 0; k < n; k++) begin
            if (k < int'(cnt)) begin
                int a;
                a = (int'(idx) + k) % 8;
                if (a != 0 && a != 7) mreg[a] = d[k] & mmask[a];
                expect_item(8'd1, "R2 data ack");
            end else begin
                expect_item(8'd0, "R5 excess data nack");
            end
            send_byte(d[k]);
        end
        bus_stop();
        wclk(4);
    endtask

    task automatic read_blk(input logic [7:0] idx, input int n, input string tag);
        bus_start();
        expect_item(8'd1, "R1 write device ack");
        send_byte(8'hD2);
        expect_item(8'd1, "R2 index ack");
        send_byte(idx);
        bus_start();
        expect_item(8'd1, "R1 read device ack");
        send_byte(8'hD3);
        expect_item(mcount, "R3 count byte");
        recv_byte(1'b1);
        for (int k = 0; k < n; k++) begin
            expect_item(view((int'(idx) + k) % 8), tag);
            recv_byte(k < n - 1);
        end
    endtask

    task automatic chk_cfg(input string tag);
        for (int i = 0; i < 8; i++) chk(tag, 64'(cfg[i*8 +: 8]), 64'(view(i)));
    endtask

    initial begin
        mreg[0] = 8'h00; mreg[1] = 8'h0F; mreg[2] = 8'h00; mreg[3] = 8'hFF;
        mreg[4] = 8'hC7; mreg[5] = 8'hDF; mreg[6] = 8'h03; mreg[7] = 8'h00;
        mmask[0] = 8'h00; mmask[1] = 8'h8F; mmask[2] = 8'hF8; mmask[3] = 8'hFF;
        mmask[4] = 8'hFF; mmask[5] = 8'hFF; mmask[6] = 8'hB7; mmask[7] = 8'h00;
        mcount = 8'd8;
        wclk(10);
        rst_n = 1'b1;
        wclk(6);

        // R9 R12: reset contents at their byte lanes; R7 R8 read-only views
        chk_cfg("R9 R12 reset contents");
        chk("R7 fsel view", 64'(cfg[7:0]), 64'h02);
        chk("R8 ident", 64'(cfg[63:56]), 64'h21);
        chk("R11 idle release", 64'(drive), 64'h0);

        // R3: full read of defaults from index 0
        read_blk(8'd0, 8, "R3 R9 read data");
        bus_stop();
        wclk(4);

        // R2: two-byte write
        write_blk(8'd3, 8'd2, 2, 8'hAA, 8'h55, 8'h00, 8'h00);
        chk_cfg("R2 R12 after write");

        // R4 R10: wrapping write over read-only and reserved bits
        write_blk(8'd6, 8'd4, 4, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        chk("R10 reg6 reserved", 64'(cfg[55:48]), 64'hB7);
        chk("R10 reg1 reserved", 64'(cfg[15:8]), 64'h8F);
        chk("R7 reg0 ignores write", 64'(cfg[7:0]), 64'h02);
        chk("R8 reg7 ignores write", 64'(cfg[63:56]), 64'h21);
        chk("R4 wrap untouched reg2", 64'(cfg[23:16]), 64'h00);

        // R4: index upper bits ignored (0x0B selects 3)
        write_blk(8'h0B, 8'd1, 1, 8'h3C, 8'h00, 8'h00, 8'h00);
        chk("R4 index modulo", 64'(cfg[31:24]), 64'h3C);

        // R5: one byte counted, two sent
        write_blk(8'd2, 8'd1, 2, 8'hF0, 8'h0F, 8'h00, 8'h00);
        chk("R5 excess not stored", 64'(cfg[31:24]), 64'h3C);
        chk("R5 counted byte", 64'(cfg[23:16]), 64'hF0);

        // R1: foreign device byte, then bytes shaped like a write
        bus_start();
        expect_item(8'd0, "R1 foreign nack");
        send_byte(8'hA0);
        expect_item(8'd0, "R1 ignored index");
        send_byte(8'h03);
        expect_item(8'd0, "R1 ignored count");
        send_byte(8'h01);
        expect_item(8'd0, "R1 ignored data");
        send_byte(8'h00);
        bus_stop();
        wclk(4);
        chk_cfg("R1 no change");

        // R4 R3 R6: wrapping read, refusal, then silence
        read_blk(8'd6, 4, "R4 wrapped read");
        expect_item(8'hFF, "R6 silent after nack");
        recv_byte(1'b0);
        bus_stop();
        wclk(4);

        // R7: live frequency-select reflection
        fsel = 2'b01;
        wclk(4);
        chk("R7 fsel follow", 64'(cfg[7:0]), 64'h01);
        read_blk(8'd0, 1, "R7 fsel read");
        bus_stop();
        wclk(10);

        chk("scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule